// File: doc/BRIEF.md
# Segment map allocator controller

This block manages a segmented word memory. Each segment is named by a 32-bit identifier and addressed by a word offset that starts at zero. All segments are carved from one flat on-chip word array. A descriptor table keeps the base address, length and live flag of every identifier. A LIFO stack holds the identifiers that have been released.

A map request takes a length in words. It returns a fresh identifier and clears every word of the new segment, which takes one cycle per word. An unmap request releases an identifier so that a later map can reuse it. Load and store requests reach one word by identifier and offset.

A program-load request copies any segment into segment 0, the code segment. Instruction fetch reads segment 0 through a separate read port. The copy lands in a new region, and segment 0 is switched over to it only on the final cycle of the copy. Fetch therefore keeps seeing the old code until the copy is complete. Flat space is handed out from a rising pointer and is not reclaimed.

Top module: `segmap_ctrl`

## Requirements
- R1: After reset, busy, done and fault are 0. Segment 0 is mapped with length zero, so a fetch at offset 0 reports a fault.
- R2: A map returns a nonzero identifier in rsp_data. The first map after reset returns 1, and each later map with an empty free stack returns the next unused identifier.
- R3: A map of length L is accepted in one cycle. busy is then high for L cycles and done pulses in the cycle busy falls. A map with L = 0 completes like a single-cycle request. Every word of the new segment loads as 0.
- R4: A store (req_op 1) writes req_data at the named identifier and offset. A load (req_op 0) returns that word in rsp_data. Both raise done in the cycle after acceptance.
- R5: An unmap (req_op 3) frees the identifier. A map (req_op 2) reuses freed identifiers in last-freed-first order before it issues new ones.
- R6: A request fails with done and fault high in the cycle after acceptance, and writes nothing, if it names an identifier that is not mapped, an identifier of NUM_IDS or more, or an offset at or beyond the segment length. An unmap of identifier 0 also fails this way.
- R7: A map whose length exceeds the remaining flat words faults and consumes no identifier. A program load from such a segment also faults.
- R8: A program load (req_op 4) of a nonzero segment of length L > 0 keeps busy high for L + 1 cycles. Afterwards segment 0 holds a copy of that segment. Later stores to the source do not change segment 0.
- R9: A program load naming segment 0 completes in the cycle after acceptance, with busy kept low, and segment 0 is unchanged.
- R10: A request presented while busy is high is ignored.
- R11: The op codes 5, 6 and 7 complete with fault.
- R12: fetch_data and fetch_fault reflect fetch_off one cycle later. fetch_fault is high when the offset is at or beyond the length of segment 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | 0 load, 1 store, 2 map, 3 unmap, 4 program load |
| req_seg | input | 32 | Segment identifier |
| req_off | input | 32 | Word offset within the segment |
| req_data | input | DW | Store data, or the length for a map |
| busy | output | 1 | A zero-fill or copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The completing request failed |
| rsp_data | output | DW | Load data or new identifier, valid with done |
| fetch_off | input | 32 | Fetch offset into segment 0 |
| fetch_data | output | DW | Fetched word, one cycle later |
| fetch_fault | output | 1 | Fetch offset out of range, one cycle later |

## Verification
Single-cycle requests finish at the first clock edge after acceptance, so done, fault and rsp_data are sampled at the next falling edge. A map of length L finishes L edges after acceptance. A copy of length L finishes L + 1 edges after acceptance. The bench computes this count from its model before it drives a request. It then checks done and busy at every falling edge until the expected one. fetch results are sampled one falling edge after fetch_off changes.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_MAP    = 3'd2,
    OP_UNMAP  = 3'd3,
    OP_LDPROG = 3'd4
  } seg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_COPY
  } seg_state_e;
endpackage

// File: rtl/seg_ram.sv
module seg_ram #(
  parameter int DW    = 32,
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [WORDS];

  // one write port, two registered read ports (read-first)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/seg_table.sv
module seg_table #(
  parameter int IDS = 8,
  parameter int AW  = 8,
  parameter int LW  = 9,
  parameter int IW  = $clog2(IDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] q_id,
  output logic          q_live,
  output logic [AW-1:0] q_base,
  output logic [LW-1:0] q_len,
  output logic [AW-1:0] z_base,
  output logic [LW-1:0] z_len,
  output logic          alloc_ok,
  output logic [IW-1:0] alloc_id,
  input  logic          do_alloc,
  input  logic          do_free,
  input  logic          do_set0,
  input  logic [AW-1:0] new_base,
  input  logic [LW-1:0] new_len
);
  localparam logic [IW:0] ID_LIM = (IW+1)'(IDS);

  logic [AW-1:0]  base_r [IDS];
  logic [LW-1:0]  len_r  [IDS];
  logic [IDS-1:0] live_r;
  logic [IW-1:0]  stk    [IDS];
  logic [IW:0]    sp, next_id;

  assign q_live   = live_r[q_id];
  assign q_base   = base_r[q_id];
  assign q_len    = len_r[q_id];
  assign z_base   = base_r[0];
  assign z_len    = len_r[0];
  assign alloc_ok = (sp != '0) || (next_id < ID_LIM);
  assign alloc_id = (sp != '0) ? stk[IW'(sp - 1'b1)] : next_id[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp      <= '0;
      next_id <= (IW+1)'(1);
      live_r  <= IDS'(1);
      for (int i = 0; i < IDS; i++) begin
        base_r[i] <= '0;
        len_r[i]  <= '0;
      end
    end else begin
      if (do_alloc) begin
        base_r[alloc_id] <= new_base;
        len_r[alloc_id]  <= new_len;
        live_r[alloc_id] <= 1'b1;
        if (sp != '0) sp <= sp - 1'b1;
        else          next_id <= next_id + 1'b1;
      end
      if (do_free) begin
        live_r[q_id] <= 1'b0;
        sp <= sp + 1'b1;
      end
      if (do_set0) begin
        base_r[0] <= new_base;
        len_r[0]  <= new_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_free) stk[sp[IW-1:0]] <= q_id;
  end

  // R2
  alloc_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    do_alloc |-> alloc_id != '0);
  // R5
  free_room_chk: assert property (@(posedge clk) disable iff (rst)
    do_free |-> sp < ID_LIM - 1'b1);
  // R6
  free_live_chk: assert property (@(posedge clk) disable iff (rst)
    do_free |-> live_r[q_id]);
endmodule

// File: rtl/segmap_ctrl.sv
module segmap_ctrl #(
  parameter int DW        = 32,
  parameter int MEM_WORDS = 256,
  parameter int NUM_IDS   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [31:0]   req_seg,
  input  logic [31:0]   req_off,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [DW-1:0] rsp_data,
  input  logic [31:0]   fetch_off,
  output logic [DW-1:0] fetch_data,
  output logic          fetch_fault
);
  import segmap_pkg::*;

  localparam int AW = $clog2(MEM_WORDS);
  localparam int LW = AW + 1;
  localparam int IW = $clog2(NUM_IDS);
  localparam logic [LW-1:0] MEM_LIM = LW'(MEM_WORDS);

  seg_state_e    state;
  logic [LW-1:0] cnt, len_r, bump, room;
  logic [AW-1:0] src_base, dst_base;
  logic [DW-1:0] rsp_q, rdata_a;
  logic          rsp_from_ram;

  logic          q_live, alloc_ok, do_alloc, do_free, do_set0;
  logic [AW-1:0] q_base, z_base, new_base;
  logic [LW-1:0] q_len, z_len, new_len;
  logic [IW-1:0] alloc_id;
  logic          we, bad, seg_ok, off_ok;
  logic [AW-1:0] waddr, raddr_a;
  logic [DW-1:0] wdata;

  seg_table #(.IDS(NUM_IDS), .AW(AW), .LW(LW), .IW(IW)) i_tab (
    .clk(clk), .rst(rst), .q_id(req_seg[IW-1:0]), .q_live(q_live),
    .q_base(q_base), .q_len(q_len), .z_base(z_base), .z_len(z_len),
    .alloc_ok(alloc_ok), .alloc_id(alloc_id), .do_alloc(do_alloc),
    .do_free(do_free), .do_set0(do_set0), .new_base(new_base), .new_len(new_len)
  );

  seg_ram #(.DW(DW), .WORDS(MEM_WORDS), .AW(AW)) i_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(raddr_a), .rdata_a(rdata_a),
    .raddr_b(z_base + fetch_off[AW-1:0]), .rdata_b(fetch_data)
  );

  assign room   = MEM_LIM - bump;
  assign seg_ok = (req_seg < 32'(NUM_IDS)) && q_live;
  assign off_ok = req_off < 32'(q_len);

  always_comb begin
    bad      = 1'b0;
    do_alloc = 1'b0;
    do_free  = 1'b0;
    do_set0  = 1'b0;
    we       = 1'b0;
    waddr    = q_base + req_off[AW-1:0];
    wdata    = req_data;
    raddr_a  = q_base + req_off[AW-1:0];
    new_base = bump[AW-1:0];
    new_len  = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        case (req_op)
          OP_LOAD:  bad = !(seg_ok && off_ok);
          OP_STORE: begin
            bad = !(seg_ok && off_ok);
            we  = !bad;
          end
          OP_MAP: begin
            bad      = !alloc_ok || (req_data > DW'(room));
            do_alloc = !bad;
            new_len  = LW'(req_data);
          end
          OP_UNMAP: begin
            bad     = !seg_ok || (req_seg == '0);
            do_free = !bad;
          end
          OP_LDPROG: begin
            bad     = !seg_ok || ((req_seg != '0) && (q_len > room));
            do_set0 = !bad && (req_seg != '0) && (q_len == '0);
          end
          default: bad = 1'b1;
        endcase
      end
      ST_FILL: begin
        we    = 1'b1;
        waddr = dst_base + cnt[AW-1:0];
        wdata = '0;
      end
      ST_COPY: begin
        raddr_a  = src_base + cnt[AW-1:0];
        we       = (cnt != '0);
        waddr    = dst_base + cnt[AW-1:0] - 1'b1;
        wdata    = rdata_a;
        do_set0  = (cnt == len_r);
        new_base = dst_base;
        new_len  = len_r;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      busy         <= 1'b0;
      done         <= 1'b0;
      fault        <= 1'b0;
      rsp_q        <= '0;
      rsp_from_ram <= 1'b0;
      cnt          <= '0;
      len_r        <= '0;
      bump         <= '0;
      src_base     <= '0;
      dst_base     <= '0;
      fetch_fault  <= 1'b1;
    end else begin
      done        <= 1'b0;
      fault       <= 1'b0;
      fetch_fault <= fetch_off >= 32'(z_len);
      unique case (state)
        ST_IDLE: if (req_valid) begin
          rsp_from_ram <= (req_op == OP_LOAD) && !bad;
          if (bad) begin
            done  <= 1'b1;
            fault <= 1'b1;
          end else if (req_op == OP_MAP) begin
            rsp_q    <= DW'(alloc_id);
            bump     <= bump + LW'(req_data);
            dst_base <= bump[AW-1:0];
            len_r    <= LW'(req_data);
            cnt      <= '0;
            if (req_data == '0) done <= 1'b1;
            else begin
              state <= ST_FILL;
              busy  <= 1'b1;
            end
          end else if (req_op == OP_LDPROG && req_seg != '0 && q_len != '0) begin
            bump     <= bump + q_len;
            src_base <= q_base;
            dst_base <= bump[AW-1:0];
            len_r    <= q_len;
            cnt      <= '0;
            state    <= ST_COPY;
            busy     <= 1'b1;
          end else begin
            done <= 1'b1;
          end
        end
        ST_FILL: begin
          cnt <= cnt + 1'b1;
          if (cnt == len_r - 1'b1) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_COPY: begin
          cnt <= cnt + 1'b1;
          if (cnt == len_r) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_data = rsp_from_ram ? rdata_a : rsp_q;

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> $stable(bump));
endmodule

// File: tb/test_segmap_ctrl.sv
module test_segmap_ctrl;
  localparam int DW = 32;
  localparam int MEM_WORDS = 256;
  localparam int NUM_IDS = 8;

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [31:0] req_seg = '0, req_off = '0, fetch_off = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, done, fault, fetch_fault;
  logic [DW-1:0] rsp_data, fetch_data;

  int checks = 0, errors = 0;

  int unsigned mdl_seg [NUM_IDS][$];
  bit          mdl_live [NUM_IDS];
  int          free_q[$];
  int          next_id;
  int          bump;

  always #10 clk = ~clk;

  segmap_ctrl #(.DW(DW), .MEM_WORDS(MEM_WORDS), .NUM_IDS(NUM_IDS)) i_segmap_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_seg(req_seg), .req_off(req_off), .req_data(req_data),
    .busy(busy), .done(done), .fault(fault), .rsp_data(rsp_data),
    .fetch_off(fetch_off), .fetch_data(fetch_data), .fetch_fault(fetch_fault)
  );

  task automatic check(bit ok, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic bit seg_bad(int unsigned seg);
    return (seg >= NUM_IDS) || !mdl_live[seg];
  endfunction

  // model step, drive, then compare done/busy at every falling edge
  task automatic run_req(input int op, input int unsigned seg, input int unsigned off,
                         input int unsigned data, input string tag, input bit poke = 1'b0);
    int lat = 0;
    bit exp_fault = 1'b0;
    bit chk_rsp = 1'b0;
    int unsigned exp_rsp = 0;
    int id;
    case (op)
      0, 1: begin
        exp_fault = seg_bad(seg) || off >= mdl_seg[seg].size();
        if (!exp_fault) begin
          if (op == 0) begin chk_rsp = 1'b1; exp_rsp = mdl_seg[seg][off]; end
          else mdl_seg[seg][off] = data;
        end
      end
      2: begin
        exp_fault = !(free_q.size() > 0 || next_id < NUM_IDS) || data > MEM_WORDS - bump;
        if (!exp_fault) begin
          if (free_q.size() > 0) id = free_q.pop_back();
          else begin id = next_id; next_id++; end
          mdl_seg[id].delete();
          repeat (data) mdl_seg[id].push_back(0);
          mdl_live[id] = 1'b1;
          bump += data;
          lat = data;
          chk_rsp = 1'b1;
          exp_rsp = id;
        end
      end
      3: begin
        exp_fault = seg_bad(seg) || seg == 0;
        if (!exp_fault) begin mdl_live[seg] = 1'b0; free_q.push_back(seg); end
      end
      4: begin
        exp_fault = seg_bad(seg) || (seg != 0 && mdl_seg[seg].size() > MEM_WORDS - bump);
        if (!exp_fault && seg != 0) begin
          lat = (mdl_seg[seg].size() == 0) ? 0 : mdl_seg[seg].size() + 1;
          bump += mdl_seg[seg].size();
          mdl_seg[0] = mdl_seg[seg];
        end
      end
      default: exp_fault = 1'b1;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_seg = seg; req_off = off; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= lat; i++) begin
      if (i > 0) @(negedge clk);
      check(done == (i == lat), {tag, " done"}, done, i == lat);
      check(busy == (i < lat), {tag, " busy"}, busy, i < lat);
      if (poke && i == 1) begin
        req_valid = 1'b1; req_op = 3'd1; req_seg = exp_rsp; req_off = 0; req_data = 32'hDEAD_BEEF;
      end
      if (poke && i == 2) req_valid = 1'b0;
    end
    check(fault == exp_fault, {tag, " fault"}, fault, exp_fault);
    if (chk_rsp) check(rsp_data == exp_rsp, {tag, " rsp"}, rsp_data, exp_rsp);
  endtask

  task automatic fetch_chk(input int unsigned off, input string tag);
    bit ef;
    @(negedge clk);
    fetch_off = off;
    @(negedge clk);
    ef = off >= mdl_seg[0].size();
    check(fetch_fault == ef, {tag, " fetch_fault"}, fetch_fault, ef);
    if (!ef) check(fetch_data == mdl_seg[0][off], {tag, " fetch_data"}, fetch_data, mdl_seg[0][off]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-reqs act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    next_id = 1; bump = 0;
    for (int i = 0; i < NUM_IDS; i++) mdl_live[i] = (i == 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !fault, "R1 reset outputs", {busy, done, fault}, 0);
    fetch_chk(0, "R1 R12 empty code");

    run_req(2, 0, 0, 4, "R2 R3 map4");
    for (int k = 0; k < 4; k++) run_req(0, 1, k, 0, "R3 zero word");
    run_req(1, 1, 2, 32'hA5A5_0002, "R4 store");
    run_req(0, 1, 2, 0, "R4 load");
    run_req(2, 0, 0, 0, "R3 map0");
    run_req(2, 0, 0, 3, "R2 map3");
    run_req(3, 2, 0, 0, "R5 unmap2");
    run_req(3, 3, 0, 0, "R5 unmap3");
    run_req(2, 0, 0, 2, "R5 reuse last");
    run_req(2, 0, 0, 1, "R5 reuse first");

    run_req(0, 7, 0, 0, "R6 unmapped id");
    run_req(0, 100, 0, 0, "R6 id range");
    run_req(0, 1, 4, 0, "R6 offset");
    run_req(1, 3, 2, 32'h1111_2222, "R6 store offset");
    run_req(0, 2, 0, 0, "R6 neighbour untouched");
    run_req(3, 0, 0, 0, "R6 unmap zero");
    run_req(3, 5, 0, 0, "R6 unmap dead");
    run_req(5, 1, 0, 0, "R11 op5");
    run_req(6, 1, 0, 0, "R11 op6");
    run_req(7, 1, 0, 0, "R11 op7");

    for (int k = 0; k < 4; k++) run_req(1, 1, k, 32'hC0DE_0000 + k, "R8 fill src");
    run_req(4, 1, 0, 0, "R8 ldprog");
    for (int k = 0; k <= 4; k++) fetch_chk(k, "R8 R12 fetch");
    run_req(1, 1, 0, 32'h0BAD_0BAD, "R8 src store");
    fetch_chk(0, "R8 copy independent");
    run_req(0, 0, 1, 0, "R8 load seg0");
    run_req(4, 0, 0, 0, "R9 ldprog0");
    fetch_chk(2, "R9 code unchanged");

    run_req(2, 0, 0, 5, "R10 map while poked", 1'b1);
    run_req(0, 4, 0, 0, "R10 poke ignored");

    run_req(2, 0, 0, 1000, "R7 too big");
    run_req(2, 0, 0, MEM_WORDS - bump, "R7 fill rest");
    run_req(2, 0, 0, 1, "R7 exhausted");
    run_req(4, 1, 0, 0, "R7 ldprog exhausted");
    run_req(2, 0, 0, 0, "R7 id not consumed");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule